// File: doc/BRIEF.md
# Presettable Up/Down Counter with Terminal-Count and Ripple-Clock Outputs

This block is a small binary counter that steps up or down by one on each rising clock edge while its active-low enable is asserted. The counter can be forced to any value at any time through an active-low load input. The load acts without a clock, tracks the data inputs for as long as it is held, and wins over counting.

Two indicators flag the end of the counting range. A terminal-count flag decodes the end state that belongs to the selected direction: all ones when counting up, zero when counting down. An active-low ripple-clock output copies the low phase of the clock while that flag is high and the enable is asserted. It stays high in every other case, so a deasserted enable blocks the pulse.

Top module: `presettable_updown_ctr`

## Requirements
- R1: While load_n is LOW, q equals d with no clock edge needed, and a change of d during the load appears on q at once.
- R2: A rising clock edge that comes while load_n is LOW leaves q equal to d, whatever ce_n and up_dn are.
- R3: With ce_n HIGH, a rising clock edge leaves q unchanged.
- R4: With ce_n LOW and up_dn LOW (count up), each rising edge adds one to q modulo 2^WIDTH, so all ones wraps to 0.
- R5: With ce_n LOW and up_dn HIGH (count down), each rising edge subtracts one from q modulo 2^WIDTH, so 0 wraps to all ones.
- R6: tc is HIGH when up_dn is LOW and q is all ones, or when up_dn is HIGH and q is 0. In every other case it is LOW. ce_n has no effect on tc.
- R7: With q held, a change of up_dn alone raises or drops tc at once. After an enabled step out of the end state, tc is LOW unless up_dn also changed.
- R8: rc_n is LOW only while tc is HIGH, ce_n is LOW and clk is LOW. It is HIGH otherwise.
- R9: When load_n returns HIGH, q keeps the loaded value until the next rising edge that has ce_n LOW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, active on its rising edge |
| load_n | input | 1 | Asynchronous parallel load, active LOW |
| ce_n | input | 1 | Count enable, active LOW |
| up_dn | input | 1 | Direction select: LOW counts up, HIGH counts down |
| d | input | WIDTH | Value to load |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal count for the selected direction |
| rc_n | output | 1 | Ripple clock, active LOW |

## Verification
A count step shows on q right after the rising edge that makes it, with no register in between. The bench therefore drives its inputs and samples q a few nanoseconds after that edge. A load, tc and the response to up_dn are combinational from their inputs, so the bench checks them a few nanoseconds after it changes the stimulus, with no clock edge in between. rc_n depends on the clock level, so the bench samples it once inside a low phase and once inside a high phase.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   // Direction encoding on up_dn
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } ctr_dir_e;

   localparam int MIN_WIDTH = 2;
endpackage

// File: rtl/ctr_step.sv
module ctr_step #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             dir,
   output logic [WIDTH-1:0] nxt
);
   import ctr_pkg::*;

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_comb begin
      if (ctr_dir_e'(dir) == DIR_UP) nxt = cur + ONE;
      else                           nxt = cur - ONE;
   end
endmodule

// File: rtl/ctr_bit.sv
module ctr_bit (
   input  logic clk,
   input  logic set_a,
   input  logic clr_a,
   input  logic en,
   input  logic nxt,
   output logic q
);
   // Storage cell with asynchronous force-to-one and force-to-zero
   always_ff @(posedge clk or posedge set_a or posedge clr_a) begin
      if (clr_a)      q <= 1'b0;
      else if (set_a) q <= 1'b1;
      else if (en)    q <= nxt;
   end
endmodule

// File: rtl/ctr_terminal.sv
module ctr_terminal #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             ce_n,
   input  logic             dir,
   input  logic [WIDTH-1:0] cur,
   output logic             tc,
   output logic             rc_n
);
   import ctr_pkg::*;

   localparam logic [WIDTH-1:0] TOP = '1;
   localparam logic [WIDTH-1:0] BOT = '0;

   always_comb begin
      if (ctr_dir_e'(dir) == DIR_UP) tc = (cur == TOP);
      else                           tc = (cur == BOT);
   end

   assign rc_n = ~(tc & ~ce_n & ~clk);
endmodule

// File: rtl/presettable_updown_ctr.sv
module presettable_updown_ctr #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic             ce_n,
   input  logic             up_dn,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             tc,
   output logic             rc_n
);
   import ctr_pkg::*;

   generate
      if (WIDTH < MIN_WIDTH) begin : g_bad_width
         $error("presettable_updown_ctr: WIDTH below minimum");
      end
   endgenerate

   logic [WIDTH-1:0] nxt;
   logic             step_en;

   assign step_en = ~ce_n;

   ctr_step #(.WIDTH(WIDTH)) u_step (
      .cur (q),
      .dir (up_dn),
      .nxt (nxt)
   );

   // One storage cell per bit; the load drives each cell's set or clear
   for (genvar b = 0; b < WIDTH; b++) begin : g_cell
      logic set_b;
      logic clr_b;
      assign set_b = ~load_n &  d[b];
      assign clr_b = ~load_n & ~d[b];
      ctr_bit u_cell (
         .clk   (clk),
         .set_a (set_b),
         .clr_a (clr_b),
         .en    (step_en),
         .nxt   (nxt[b]),
         .q     (q[b])
      );
   end

   ctr_terminal #(.WIDTH(WIDTH)) u_term (
      .clk  (clk),
      .ce_n (ce_n),
      .dir  (up_dn),
      .cur  (q),
      .tc   (tc),
      .rc_n (rc_n)
   );

   // Marks a clock period touched by a load, so the step checks skip it
   logic ld_recent;
   always_ff @(posedge clk or negedge load_n) begin
      if (!load_n) ld_recent <= 1'b1;
      else         ld_recent <= 1'b0;
   end

   a_r3_hold: assert property (@(posedge clk) disable iff (ld_recent || !load_n)
      ce_n |=> $stable(q));

   a_r4_up_step: assert property (@(posedge clk) disable iff (ld_recent || !load_n)
      (!ce_n && !up_dn) |=> (q == WIDTH'($past(q) + 1'b1)));

   a_r5_down_step: assert property (@(posedge clk) disable iff (ld_recent || !load_n)
      (!ce_n && up_dn) |=> (q == WIDTH'($past(q) - 1'b1)));

   a_r7_tc_leaves: assert property (@(posedge clk) disable iff (ld_recent || !load_n)
      (tc && !ce_n) |=> (!tc || (up_dn != $past(up_dn))));

   a_r8_rc_needs_tc: assert property (@(posedge clk) disable iff (!load_n)
      !tc |-> rc_n);
endmodule

// File: tb/presettable_updown_ctr_test.sv
`timescale 1ns/1ps
module presettable_updown_ctr_test;
   localparam int W = 4;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         load_n;
   logic         ce_n;
   logic         up_dn;
   logic [W-1:0] d;
   logic [W-1:0] q;
   logic         tc;
   logic         rc_n;

   int errors = 0;
   int checks = 0;

   presettable_updown_ctr #(.WIDTH(W)) uut (
      .clk(clk), .load_n(load_n), .ce_n(ce_n), .up_dn(up_dn),
      .d(d), .q(q), .tc(tc), .rc_n(rc_n)
   );

   always #10 clk = ~clk;   // 50 MHz

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Advance one rising edge, then settle 5 ns
   task automatic tick;
      @(posedge clk);
      #5;
   endtask

   task automatic do_load(input int v);
      d = W'(v);
      load_n = 1'b0;
      #3;
      load_n = 1'b1;
      #2;
   endtask

   task automatic t_load;
      ce_n = 1'b0; up_dn = 1'b0;
      @(posedge clk);
      // load asserted at the same moment as a clock edge
      load_n = 1'b0; d = 4'd9;
      #3;
      check("R1 load applies", int'(q), 9);
      d = 4'd4;
      #3;
      check("R1 load follows d", int'(q), 4);
      tick();
      check("R2 load beats edge", int'(q), 4);
      load_n = 1'b1; ce_n = 1'b1;
      #2;
      check("R9 value after release", int'(q), 4);
      tick();
      check("R3 hold with ce_n high", int'(q), 4);
      check("R9 kept until enabled edge", int'(q), 4);
      ce_n = 1'b0;
      tick();
      check("R9 first enabled edge steps", int'(q), 5);
   endtask

   task automatic t_up;
      ce_n = 1'b1; up_dn = 1'b0;
      do_load(13);
      ce_n = 1'b0;
      tick(); check("R4 up 13->14", int'(q), 14);
      check("R6 no tc at 14", int'(tc), 0);
      tick(); check("R4 up 14->15", int'(q), 15);
      check("R6 tc at top counting up", int'(tc), 1);
      tick(); check("R4 wrap 15->0", int'(q), 0);
      check("R7 tc drops after step", int'(tc), 0);
      tick(); check("R4 up 0->1", int'(q), 1);
   endtask

   task automatic t_down;
      ce_n = 1'b1; up_dn = 1'b1;
      do_load(2);
      ce_n = 1'b0;
      tick(); check("R5 down 2->1", int'(q), 1);
      tick(); check("R5 down 1->0", int'(q), 0);
      check("R6 tc at zero counting down", int'(tc), 1);
      tick(); check("R5 wrap 0->15", int'(q), MAXV);
      check("R6 no tc at 15 counting down", int'(tc), 0);
      ce_n = 1'b1;
      tick(); check("R3 hold while counting down", int'(q), MAXV);
   endtask

   task automatic t_dir;
      ce_n = 1'b1; up_dn = 1'b0;
      do_load(MAXV);
      check("R6 tc with ce_n high", int'(tc), 1);
      up_dn = 1'b1; #2;
      check("R7 direction drop", int'(tc), 0);
      do_load(0);
      check("R7 load into end state", int'(tc), 1);
      up_dn = 1'b0; #2;
      check("R7 direction drop at zero", int'(tc), 0);
      up_dn = 1'b1; #2;
      check("R7 direction raise at zero", int'(tc), 1);
   endtask

   task automatic t_rc;
      ce_n = 1'b1; up_dn = 1'b0;
      do_load(MAXV);
      @(negedge clk); #2;
      check("R8 rc_n high when disabled", int'(rc_n), 1);
      ce_n = 1'b0; #1;
      check("R8 rc_n low in low phase", int'(rc_n), 0);
      @(posedge clk); #2;
      check("R4 wrap on rc edge", int'(q), 0);
      check("R8 rc_n high once tc low", int'(rc_n), 1);
      ce_n = 1'b1;
      do_load(MAXV);
      ce_n = 1'b0;
      #1;
      check("R8 rc_n high in high phase", int'(rc_n), 1);
      @(negedge clk); #2;
      check("R8 rc_n low again", int'(rc_n), 0);
      ce_n = 1'b1; #1;
      check("R8 ce_n suppresses pulse", int'(rc_n), 1);
   endtask

   initial begin
      load_n = 1'b1; ce_n = 1'b1; up_dn = 1'b0; d = '0;
      #1;
      load_n = 1'b0;
      #3;
      check("R1 initial load", int'(q), 0);
      load_n = 1'b1;
      t_load();
      t_up();
      t_down();
      t_dir();
      t_rc();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #4000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule